// File: doc/BRIEF.md
# Multiplexed Four-Digit BCD Seven-Segment Driver

This block lights a row of four common-anode seven-segment digits from a 16-bit packed BCD value, using a single shared BCD-to-segment decoder. A free-running scan select walks through the digits in turn. The same select value picks one 4-bit nibble from the input for the decoder and raises the enable of the matching digit, so the pattern on the shared segment bus always belongs to the digit that is powered.

A refresh divider sets how long each digit stays selected: the select advances once every `REFRESH_DIV` clock cycles, giving the order 0, 1, 2, 3, 0 and so on. Segment lines are active low, because the segments of a common-anode display sink current. Digit enables are active high and drive the anode switch of the selected digit. On the first cycle of every digit's dwell the segment bus is held dark, so the pattern of the previous digit never flashes on the new one. Nibble codes above nine light no segment.

All outputs are registered. A change on the BCD input reaches the segment bus one clock later.

Top module: `disp_scan_top`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `seg_n` is 7'h7F (all dark) and `dig_en` is 4'b0001.
- R2: Exactly one bit of `dig_en` is high in every cycle.
- R3: The selected digit advances once every `REFRESH_DIV` cycles in the order 0, 1, 2, 3, 0. Counting edges after reset release from m = 0, the output after edge m+1 enables digit (m / REFRESH_DIV) mod 4.
- R4: When `dig_en[k]` is high, the segment bus shows the decode of `bcd_in[4k+3:4k]` as sampled at the clock edge that loaded the outputs.
- R5: For codes 0 to 9, `seg_n` is the active-low pattern with bit 0 = a up to bit 6 = g; lit segments (active-high hex, bit 0 = a) are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F.
- R6: For codes 0 to 9, segment a is lit exactly when b3 OR b1 OR (b0 AND b2) OR (NOT b0 AND NOT b2) holds, with b3 the nibble's top bit.
- R7: Codes 10 to 15 drive `seg_n` to 7'h7F.
- R8: In the first cycle that a digit is enabled (m mod `REFRESH_DIV` = 0 in R3's count), `seg_n` is 7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 16 | Four packed BCD nibbles, digit k in bits 4k+3..4k |
| seg_n | output | 7 | Shared segment bus, active low, bit 0 = a .. bit 6 = g |
| dig_en | output | 4 | Digit anode enables, active high, one-hot |

## Verification
The bench runs the scan with four distinct digits so that a swapped nibble or a misrouted enable shows up as a wrong pattern on a specific digit, with all digits equal so that each code 0 to 9 is compared against its full segment pattern, and with codes above nine mixed among valid ones so blanking is told apart from a decoder that lets the formula for segment a through. An input change in the middle of a dwell checks the one-cycle latency, and a second reset mid-scan checks that the select restarts at digit 0 with a dark first cycle.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  localparam int SEG_W = 7;
  localparam int NIB_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [NIB_W-1:0] nib_t;
  localparam seg_t SEG_DARK = '1;
endpackage

// File: rtl/refresh_div.sv
module refresh_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R3: the divider count never leaves its range
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/scan_sel.sv
module scan_sel #(
  parameter int N_DIG = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  output logic [$clog2(N_DIG)-1:0] sel,
  output logic [N_DIG-1:0]         sel_oh
);
  localparam int SW = $clog2(N_DIG);
  localparam logic [SW-1:0] TOP = SW'(N_DIG - 1);

  always_ff @(posedge clk) begin
    if (rst) sel <= '0;
    else if (adv) sel <= (sel == TOP) ? '0 : sel + 1'b1;
  end

  for (genvar k = 0; k < N_DIG; k++) begin : g_dec
    assign sel_oh[k] = (sel == SW'(k));
  end

  // R3: each advance moves to the next digit, wrapping after the last
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (adv && sel != TOP) |=> sel == $past(sel) + 1'b1);
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && sel == TOP) |=> sel == '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(sel));
endmodule

// File: rtl/bcd7_decode.sv
module bcd7_decode
  import dscan_pkg::*;
(
  input  nib_t nib,
  output seg_t seg_n
);
  logic b0, b1, b2, b3, ok, a_on;
  logic [SEG_W-1:1] rest;

  assign {b3, b2, b1, b0} = nib;
  assign ok   = (nib <= 4'd9);
  assign a_on = b3 | b1 | (b0 & b2) | (~b0 & ~b2);

  // segments b..g, active high, bit order g f e d c b
  always_comb begin
    unique case (nib)
      4'd0:    rest = 6'b011111;
      4'd1:    rest = 6'b000011;
      4'd2:    rest = 6'b101101;
      4'd3:    rest = 6'b100111;
      4'd4:    rest = 6'b110011;
      4'd5:    rest = 6'b110110;
      4'd6:    rest = 6'b111110;
      4'd7:    rest = 6'b000011;
      4'd8:    rest = 6'b111111;
      4'd9:    rest = 6'b110111;
      default: rest = 6'b000000;
    endcase
  end

  assign seg_n = ~({rest, a_on} & {SEG_W{ok}});
endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top
  import dscan_pkg::*;
#(
  parameter int REFRESH_DIV = 50000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bcd_in,
  output logic [6:0]  seg_n,
  output logic [3:0]  dig_en
);
  localparam int N_DIG = 4;
  localparam int SW    = $clog2(N_DIG);

  logic          tick;
  logic [SW-1:0] sel;
  logic [N_DIG-1:0] sel_oh;
  nib_t          nib_arr [N_DIG];
  nib_t          nib_sel;
  seg_t          dec_n;
  logic          chg_q;

  refresh_div #(.DIV(REFRESH_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(tick)
  );

  scan_sel #(.N_DIG(N_DIG)) u_sel (
    .clk(clk), .rst(rst), .adv(tick), .sel(sel), .sel_oh(sel_oh)
  );

  for (genvar k = 0; k < N_DIG; k++) begin : g_nib
    assign nib_arr[k] = bcd_in[NIB_W*k +: NIB_W];
  end
  assign nib_sel = nib_arr[sel];

  bcd7_decode u_dec (.nib(nib_sel), .seg_n(dec_n));

  // chg_q marks that sel has just moved (reset counts as a move)
  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q  <= 1'b1;
      seg_n  <= SEG_DARK;
      dig_en <= 4'b0001;
    end else begin
      chg_q  <= tick;
      seg_n  <= chg_q ? SEG_DARK : dec_n;
      dig_en <= sel_oh;
    end
  end

  // R1: the first cycle after reset is dark on digit 0
  a_r1_after_rst: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seg_n == SEG_DARK && dig_en == 4'b0001));
  // R2: one digit enable at a time
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_en) == 1);
  // R8: a newly enabled digit starts dark
  a_r8_blank_on_switch: assert property (@(posedge clk) disable iff (rst)
    !$stable(dig_en) |-> seg_n == SEG_DARK);
  // R7: codes above nine never light a segment
  a_r7_invalid_dark: assert property (@(posedge clk) disable iff (rst)
    (nib_sel > 4'd9) |=> seg_n == SEG_DARK);
  // R4: enable follows the select that fed the decoder
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dig_en[$past(sel)]);
endmodule

// File: tb/disp_scan_top_bench.sv
module disp_scan_top_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bcd_in = 16'h0000;
  logic [6:0]  seg_n;
  logic [3:0]  dig_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [3:0] en;
    logic [6:0] sg;
    string      tag;
    logic [3:0] nib;
    bit         lit;
  } item_t;

  item_t q[$];
  int m = 0;

  always #5 clk = ~clk;

  disp_scan_top #(.REFRESH_DIV(DIV)) u_disp_scan_top (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .seg_n(seg_n), .dig_en(dig_en)
  );

  function automatic logic [6:0] lit_pat(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: predict each registered output
  always @(posedge clk) begin
    if (rst) begin
      m = 0;
      q.delete();
    end else begin
      item_t it;
      int dg;
      dg = (m / DIV) % 4;
      it.en  = 4'(1 << dg);
      it.nib = bcd_in[4*dg +: 4];
      if (m % DIV == 0) begin
        it.sg = 7'h7F; it.tag = "R8"; it.lit = 1'b0;
      end else if (it.nib > 4'd9) begin
        it.sg = 7'h7F; it.tag = "R7"; it.lit = 1'b0;
      end else begin
        it.sg = ~lit_pat(it.nib); it.tag = "R4"; it.lit = 1'b1;
      end
      q.push_back(it);
      m++;
    end
  end

  // monitor side: compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check($countones(dig_en) == 1, "R2", "one-hot enable", {12'h0, dig_en}, 16'h0);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(dig_en == it.en, "R3", "digit enable", {12'h0, dig_en}, {12'h0, it.en});
        check(seg_n == it.sg, it.tag, "segments", {9'h0, seg_n}, {9'h0, it.sg});
        if (it.lit) begin
          logic b0, b1, b2, b3, a_exp;
          {b3, b2, b1, b0} = it.nib;
          a_exp = b3 | b1 | (b0 & b2) | (~b0 & ~b2);
          check(seg_n[0] == ~a_exp, "R6", "segment a", {15'h0, seg_n[0]}, {15'h0, ~a_exp});
        end
      end
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    run_cycles(3);
    check(seg_n == 7'h7F, "R1", "segments in reset", {9'h0, seg_n}, 16'h7F);
    check(dig_en == 4'b0001, "R1", "enable in reset", {12'h0, dig_en}, 16'h1);
    rst = 1'b0;
    @(negedge clk);
    check(seg_n == 7'h7F, "R1", "segments after reset", {9'h0, seg_n}, 16'h7F);
    check(dig_en == 4'b0001, "R1", "enable after reset", {12'h0, dig_en}, 16'h1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bcd_in = 16'h4321;
    do_reset();
    run_cycles(3 * 4 * DIV);          // R4: distinct digits
    bcd_in = 16'h8765;
    run_cycles(2 * 4 * DIV + 2);
    bcd_in = 16'h9090;                // change mid-dwell
    run_cycles(2 * 4 * DIV + 1);
    bcd_in = 16'hA3F7;                // R7: codes above nine mixed in
    run_cycles(2 * 4 * DIV);
    bcd_in = 16'hCBED;
    run_cycles(4 * DIV);

    // R5: every code on all digits, explicit pattern check
    for (int d = 0; d < 10; d++) begin
      bcd_in = {4{4'(d)}};
      run_cycles(2);
      if (seg_n == 7'h7F) run_cycles(1);
      check(seg_n == ~lit_pat(4'(d)), "R5", "decode table",
            {9'h0, seg_n}, {9'h0, ~lit_pat(4'(d))});
    end

    do_reset();                       // R1 again, mid-scan
    bcd_in = 16'h0246;
    run_cycles(3 * 4 * DIV);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule